// File: doc/BRIEF.md
# Embedded Operation Timer with Status Readback

This block times the internal program and erase operations of a word-wide non-volatile array once a command controller has accepted the command. A single-cycle start pulse carries the operation type and the word that was last loaded. The block then counts down a duration chosen by the operation type, because a word program is far shorter than an erase. It raises a busy flag for the whole operation and issues a one-cycle completion pulse that tells the array to commit the result.

While the operation runs, a read does not return array contents. It returns a status word that software can poll in either of two ways. The first is a polling bit: during a program it carries the inverse of the loaded data's bit, and during an erase it carries zero. The second is a toggle bit that changes value with every read access. Once the operation ends, reads return array data again on every bit. The block also produces the output-drive enable, so the data pins are driven only during a valid read access.

Top module: `optimer_status`

## Requirements
- R1: During and directly after reset, busy_o, done_o and drive_en_o are 0 and rdata_o is all zero while no read is active.
- R2: An accepted program start keeps busy_o high for exactly PROG_CYC cycles, and an erase start keeps it high for exactly ERASE_CYC cycles. Busy rises on the clock edge that samples start_i. done_o is high for exactly one cycle, which is the last busy cycle. After that cycle busy_o is 0.
- R3: A start_i pulse that arrives while busy_o is high is ignored. The running operation keeps its original length and its original type.
- R4: While a program operation is busy, rdata_o bit 7 reads as the inverse of bit 7 of last_data_i, as captured at the accepted start.
- R5: While an erase operation is busy, rdata_o bit 7 reads as 0.
- R6: While busy, rdata_o bit 6 reads 0 on the first read access after an accepted start. It then takes the opposite value on each following read access. A read access is a run of cycles with drive_en_o high, and a new access begins only after drive_en_o has been low. Bit 6 does not change within an access.
- R7: While busy, every rdata_o bit other than 6 and 7 reads as 0, whatever array_data_i holds.
- R8: While not busy, rdata_o equals array_data_i during a read access, and bit 6 stays at the array value across repeated reads.
- R9: drive_en_o is 1 exactly when rd_ce_n_i = 0, rd_oe_n_i = 0 and rd_we_n_i = 1. rdata_o is all zero whenever drive_en_o is 0.
- R10: The operation type and data bit 7 are captured only at an accepted start. Later changes to op_erase_i or last_data_i during busy do not alter the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request from the command controller to begin an operation |
| op_erase_i | input | 1 | Operation type at start: 1 = erase, 0 = word program |
| last_data_i | input | DW | Word most recently loaded for programming |
| rd_ce_n_i | input | 1 | Active-low chip select from the bus |
| rd_oe_n_i | input | 1 | Active-low output enable from the bus |
| rd_we_n_i | input | 1 | Active-low write enable from the bus |
| array_data_i | input | DW | Word read from the array at the current address |
| busy_o | output | 1 | High while an operation is being timed |
| done_o | output | 1 | One-cycle commit pulse to the array at the end of an operation |
| drive_en_o | output | 1 | Enable for the data pin drivers |
| rdata_o | output | DW | Read word: status while busy, array data otherwise |

## Verification
The assertions assume that start_i, op_erase_i and the read strobes are synchronous to clk and are stable around the sampling edge. They also assume that the bus control pins never take unknown values after reset. The bench changes every input on the falling clock edge and samples outputs five nanoseconds later. Each read access is separated from the next by at least one cycle with output enable high, so every access is a distinct event for the toggle bit. A restart pulse is sent only while an operation is already running, which exercises the ignore path without leaving the assumed protocol.

// File: rtl/optimer_pkg.sv
package optimer_pkg;

   // operation kinds latched at an accepted start
   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } op_kind_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/optimer_count.sv
module optimer_count #(
   parameter int unsigned PROG_CYC  = 500,
   parameter int unsigned ERASE_CYC = 100000,
   localparam int unsigned CW = $clog2(optimer_pkg::max_u(PROG_CYC, ERASE_CYC) + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept_i,
   input  logic erase_i,
   output logic busy_o,
   output logic done_o
);

   localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYC - 1);
   localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept_i) begin
         busy_q <= 1'b1;
         cnt_q  <= erase_i ? ERASE_LOAD : PROG_LOAD;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_busy_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> (busy_o && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/optimer_toggle.sv
module optimer_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic busy_i,
   input  logic rd_act_i,
   output logic tog_o
);

   logic rd_q;
   logic tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         tog_q <= 1'b0;
      end else begin
         rd_q <= rd_act_i;
         if (clear_i)
            tog_q <= 1'b0;
         else if (busy_i && rd_q && !rd_act_i)
            tog_q <= ~tog_q;
      end
   end

   assign tog_o = tog_q;

   assert_toggle_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act_i && !clear_i) |=> $stable(tog_o));
   assert_toggle_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !tog_o);

endmodule

// File: rtl/optimer_rdmux.sv
module optimer_rdmux #(
   parameter int unsigned DW        = 16,
   parameter int unsigned POLL_BIT  = 7,
   parameter int unsigned TOG_BIT   = 6,
   parameter bit          GATE_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy_i,
   input  logic          erase_i,
   input  logic          poll_i,
   input  logic          tog_i,
   input  logic          drive_i,
   input  logic [DW-1:0] array_i,
   output logic [DW-1:0] rdata_o
);

   logic [DW-1:0] status_w;
   logic [DW-1:0] word_w;

   always_comb begin
      status_w           = '0;
      status_w[POLL_BIT] = erase_i ? 1'b0 : ~poll_i;
      status_w[TOG_BIT]  = tog_i;
      word_w             = busy_i ? status_w : array_i;
   end

   generate
      if (GATE_IDLE) begin : g_gated
         assign rdata_o = drive_i ? word_w : '0;
         assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !drive_i |-> (rdata_o == '0));
      end else begin : g_open
         assign rdata_o = word_w;
      end
   endgenerate

   assert_status_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> ((rdata_o & ~((DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT))) == '0));

endmodule

// File: rtl/optimer_status.sv
module optimer_status #(
   parameter int unsigned DW        = 16,
   parameter int unsigned PROG_CYC  = 500,
   parameter int unsigned ERASE_CYC = 100000,
   parameter int unsigned POLL_BIT  = 7,
   parameter int unsigned TOG_BIT   = 6,
   parameter bit          GATE_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          op_erase_i,
   input  logic [DW-1:0] last_data_i,
   input  logic          rd_ce_n_i,
   input  logic          rd_oe_n_i,
   input  logic          rd_we_n_i,
   input  logic [DW-1:0] array_data_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          drive_en_o,
   output logic [DW-1:0] rdata_o
);

   import optimer_pkg::*;

   generate
      if (DW <= POLL_BIT || DW <= TOG_BIT || POLL_BIT == TOG_BIT)
         $error("optimer_status: status bit positions do not fit the word");
      if (PROG_CYC < 1 || ERASE_CYC < 1)
         $error("optimer_status: durations must be at least one cycle");
   endgenerate

   logic     busy_w;
   logic     accept_w;
   logic     tog_w;
   op_kind_e kind_q;
   logic     poll_q;
   logic     unused_data;

   assign unused_data = ^last_data_i;
   assign accept_w    = start_i && !busy_w;
   assign drive_en_o  = !rd_ce_n_i && !rd_oe_n_i && rd_we_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= OP_PROGRAM;
         poll_q <= 1'b0;
      end else if (accept_w) begin
         kind_q <= op_erase_i ? OP_ERASE : OP_PROGRAM;
         poll_q <= last_data_i[POLL_BIT];
      end
   end

   optimer_count #(
      .PROG_CYC  (PROG_CYC),
      .ERASE_CYC (ERASE_CYC)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept_w),
      .erase_i  (op_erase_i),
      .busy_o   (busy_w),
      .done_o   (done_o)
   );

   optimer_toggle u_toggle (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (accept_w),
      .busy_i   (busy_w),
      .rd_act_i (drive_en_o),
      .tog_o    (tog_w)
   );

   optimer_rdmux #(
      .DW        (DW),
      .POLL_BIT  (POLL_BIT),
      .TOG_BIT   (TOG_BIT),
      .GATE_IDLE (GATE_IDLE)
   ) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_i  (busy_w),
      .erase_i (kind_q == OP_ERASE),
      .poll_i  (poll_q),
      .tog_i   (tog_w),
      .drive_i (drive_en_o),
      .array_i (array_data_i),
      .rdata_o (rdata_o)
   );

   assign busy_o = busy_w;

   assert_kind_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && !start_i) |=> $stable(kind_q) && $stable(poll_q));
   assert_erase_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && drive_en_o && kind_q == OP_ERASE) |-> !rdata_o[POLL_BIT]);

endmodule

// File: tb/sim_optimer_status.sv
module sim_optimer_status;

   localparam int DW = 16;
   localparam int PC = 8;
   localparam int EC = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          op_erase_i = 1'b0;
   logic [DW-1:0] last_data_i = '0;
   logic          rd_ce_n_i = 1'b1;
   logic          rd_oe_n_i = 1'b1;
   logic          rd_we_n_i = 1'b1;
   logic [DW-1:0] array_data_i = '0;
   logic          busy_o, done_o, drive_en_o;
   logic [DW-1:0] rdata_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   optimer_status #(.DW(DW), .PROG_CYC(PC), .ERASE_CYC(EC)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
      .last_data_i(last_data_i), .rd_ce_n_i(rd_ce_n_i), .rd_oe_n_i(rd_oe_n_i),
      .rd_we_n_i(rd_we_n_i), .array_data_i(array_data_i), .busy_o(busy_o),
      .done_o(done_o), .drive_en_o(drive_en_o), .rdata_o(rdata_o)
   );

   // {ce_n, oe_n, we_n, expected drive}
   localparam logic [3:0] VEC [8] = '{
      4'b000_0, 4'b001_1, 4'b010_0, 4'b011_0,
      4'b100_0, 4'b101_0, 4'b110_0, 4'b111_0
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one read access of one cycle, then one idle cycle
   task automatic do_read(input string req, input logic [DW-1:0] exp);
      @(negedge clk);
      rd_ce_n_i = 1'b0; rd_oe_n_i = 1'b0; rd_we_n_i = 1'b1;
      #5 chk(req, 32'(rdata_o), 32'(exp));
      @(negedge clk);
      rd_ce_n_i = 1'b1; rd_oe_n_i = 1'b1;
   endtask

   task automatic kick(input logic erase, input logic [DW-1:0] data);
      @(negedge clk);
      start_i = 1'b1; op_erase_i = erase; last_data_i = data;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000 && busy_o; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic measure(input string req, input logic erase, input int restart_at,
                          input int exp_len);
      int n = 0, dn = 0;
      logic last_done = 1'b0;
      @(negedge clk);
      start_i = 1'b1; op_erase_i = erase; last_data_i = 16'h0000;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         start_i = (restart_at != 0 && n + 1 == restart_at);
         op_erase_i = start_i ? ~erase : erase;
         #5;
         if (!busy_o) break;
         n++;
         if (done_o) dn++;
         last_done = done_o;
      end
      start_i = 1'b0;
      chk({req, " busy length"}, n, exp_len);
      chk({req, " done count"}, dn, 1);
      chk({req, " done on last busy cycle"}, 32'(last_done), 1);
      chk({req, " done low after end"}, 32'(done_o), 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      chk("R1 busy in reset", 32'(busy_o), 0);
      chk("R1 done in reset", 32'(done_o), 0);
      chk("R1 drive in reset", 32'(drive_en_o), 0);
      chk("R1 rdata in reset", 32'(rdata_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #5 chk("R1 busy after reset", 32'(busy_o), 0);

      // R9 / R8: strobe combinations while idle
      array_data_i = 16'hA5C3;
      foreach (VEC[i]) begin
         @(negedge clk);
         {rd_ce_n_i, rd_oe_n_i, rd_we_n_i} = VEC[i][3:1];
         #5;
         chk("R9 drive enable decode", 32'(drive_en_o), 32'(VEC[i][0]));
         chk("R9 R8 idle rdata", 32'(rdata_o), VEC[i][0] ? 32'h0000A5C3 : 32'h0);
      end
      @(negedge clk);
      rd_ce_n_i = 1'b1; rd_oe_n_i = 1'b1; rd_we_n_i = 1'b1;

      // R2: durations per operation type
      measure("R2 program", 1'b0, 0, PC);
      measure("R2 erase", 1'b1, 0, EC);

      // R3: restart while busy is ignored
      measure("R3 restart ignored", 1'b0, 3, PC);

      // R4 R6 R7: program polling, bit7 of data = 1 -> status bit7 = 0
      array_data_i = 16'hFFFF;
      kick(1'b0, 16'h0080);
      do_read("R4 R6 R7 first program read", 16'h0000);
      do_read("R6 second read toggles", 16'h0040);
      do_read("R6 third read toggles back", 16'h0000);
      wait_idle();

      // R8: idle reads return array data, bit 6 steady
      array_data_i = 16'h1274;
      do_read("R8 idle read one", 16'h1274);
      do_read("R8 idle read two", 16'h1274);

      // R5: erase polling bit reads 0
      array_data_i = 16'hFFFF;
      kick(1'b1, 16'h0080);
      do_read("R5 erase first read", 16'h0000);
      do_read("R5 R6 erase second read", 16'h0040);
      wait_idle();

      // R4 R10: program with bit7 = 0 -> status bit7 = 1; later input changes ignored
      kick(1'b0, 16'h0000);
      do_read("R4 program bit7 inverted", 16'h0080);
      op_erase_i = 1'b1; last_data_i = 16'hFFFF;
      do_read("R10 captured type and data", 16'h00C0);
      wait_idle();
      op_erase_i = 1'b0;
      chk("R2 idle after program", 32'(busy_o), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule